// File: doc/BRIEF.md
# Zoned Data Memory Wait-State Controller

This block sits between a processor core and its off-chip data memory. It runs every data-memory access the core issues. The core presents a 14-bit word address, a read or write request and 16-bit write data. The controller sorts each address into one of two places. Addresses from 0x3800 upward belong to on-chip storage, which this block only recognises and flags. Every lower address belongs to external memory.

External space is split into five fixed zones of unequal size. The zone an address falls in selects a 3-bit wait count from a 15-bit configuration register. The controller then holds an active-low select, plus a read strobe or a write strobe, for one base cycle plus that many wait cycles. It raises a one-cycle done pulse in the final cycle. Read data is captured at the end of that final cycle. The configuration register is loaded through a single write port, and every zone comes out of reset at the slowest setting.

Top module: `dmem_zone_ctrl`

## Requirements
- R1: After reset, sel_n, rd_n and wr_n are high, done and onchip are low, and every zone's wait count is 7, so an external access lasts 8 cycles.
- R2: External addresses map to zones as follows: 0x0000–0x03FF is zone 0, 0x0400–0x07FF is zone 1, 0x0800–0x2FFF is zone 2, 0x3000–0x33FF is zone 3 and 0x3400–0x37FF is zone 4. Zone k takes its wait count from cfg_wdata bits [3k+2:3k].
- R3: A request is accepted at a clock edge while the controller is idle. An external access then holds sel_n low for exactly N+1 cycles from the following cycle, where N is the zone's count. done is high only in the last of those cycles and lasts one cycle.
- R4: During an external access, rd_n is low for reads (req_we=0) and wr_n is low for writes (req_we=1), in every cycle that sel_n is low. rd_n and wr_n are never low together, and neither is low while sel_n is high.
- R5: A request to an address of 0x3800 or above drives no strobe. It gives done and onchip high together for exactly one cycle, the cycle after acceptance.
- R6: For a read, rdata takes the value of mem_rdata from the final access cycle. It holds that value from the next cycle until another external read completes. Writes and on-chip accesses leave it unchanged.
- R7: mem_addr and mem_wdata carry the accepted request's address and data and stay stable for the whole access.
- R8: A request raised while an access is in progress is ignored. It does not lengthen the access, does not change mem_addr and does not start a later access.
- R9: A configuration write applies to accesses accepted after the edge on which it is written. An access already in progress keeps the count it latched when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the wait-count register |
| cfg_wdata | input | 15 | Five 3-bit wait counts, zone 0 in the low bits |
| req | input | 1 | Access request from the core |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address of the access |
| req_wdata | input | 16 | Write data |
| mem_rdata | input | 16 | Data returned by external memory |
| mem_addr | output | 14 | Address driven to external memory |
| mem_wdata | output | 16 | Write data driven to external memory |
| mem_sel_n | output | 1 | Active-low data memory select |
| mem_rd_n | output | 1 | Active-low read strobe / output enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle completion pulse to the core |
| onchip | output | 1 | High with done when the access was on-chip |
| rdata | output | 16 | Captured read data |

## Verification
Accesses are made to the first and last word of every zone and to both ends of the on-chip region. This is done first with the reset counts and then with five distinct programmed counts, so a wrong boundary or a wrong field choice shows up as a wrong strobe length. Reads alternate with writes so the strobe choice and the holding of rdata can be told apart. A request injected mid-access and a configuration write mid-access separate "accepted only when idle" and "count latched at acceptance" from looser behaviour. A behavioural model compares every output on every clock.

// File: rtl/dmz_pkg.sv
package dmz_pkg;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 3;
    localparam int NZONES = 5;
    localparam int ZONE_W = $clog2(NZONES);
    localparam int CFG_W  = NZONES * WAIT_W;

    // Last word of each external zone; decode priority depends on this order.
    localparam logic [ADDR_W-1:0] ZONE_LAST [NZONES] =
        '{14'h03FF, 14'h07FF, 14'h2FFF, 14'h33FF, 14'h37FF};
    localparam logic [ADDR_W-1:0] ONCHIP_BASE = 14'h3800;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXT  = 2'd1,
        ST_INT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dmz_decode.sv
module dmz_decode
    import dmz_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [ZONE_W-1:0] zone,
    output logic              is_onchip
);
    always_comb begin
        is_onchip = (addr >= ONCHIP_BASE);
        zone      = ZONE_W'(NZONES - 1);
        for (int k = NZONES - 1; k >= 0; k--) begin
            if (addr <= ZONE_LAST[k]) begin
                zone = ZONE_W'(k);
            end
        end
    end
endmodule

// File: rtl/dmz_cfg.sv
module dmz_cfg
    import dmz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    input  logic [ZONE_W-1:0] zone,
    output logic [WAIT_W-1:0] wait_sel
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = we ? wdata : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '1;
        else        cfg_q <= cfg_d;
    end

    logic [WAIT_W-1:0] field [NZONES];
    for (genvar g = 0; g < NZONES; g++) begin : g_field
        assign field[g] = cfg_q[g*WAIT_W +: WAIT_W];
    end

    always_comb begin
        wait_sel = field[0];
        for (int k = 1; k < NZONES; k++) begin
            if (zone == ZONE_W'(k)) wait_sel = field[k];
        end
    end
endmodule

// File: rtl/dmz_seq.sv
module dmz_seq
    import dmz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              is_onchip,
    input  logic [WAIT_W-1:0] wait_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              done,
    output logic              onchip,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        seq_state_e        st;
        logic [WAIT_W-1:0] cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.addr  = req_addr;
                    s_d.we    = req_we;
                    s_d.wdata = req_wdata;
                    s_d.cnt   = wait_sel;
                    s_d.st    = is_onchip ? ST_INT : ST_EXT;
                end
            end
            ST_EXT: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_IDLE;
                    if (!s_q.we) s_d.rdata = mem_rdata;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_INT:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, we: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.wdata;
    assign mem_sel_n = (s_q.st != ST_EXT);
    assign mem_rd_n  = !((s_q.st == ST_EXT) && !s_q.we);
    assign mem_wr_n  = !((s_q.st == ST_EXT) && s_q.we);
    assign done      = ((s_q.st == ST_EXT) && (s_q.cnt == '0)) || (s_q.st == ST_INT);
    assign onchip    = (s_q.st == ST_INT);
    assign rdata     = s_q.rdata;

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n)); // R4
    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !mem_sel_n); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        onchip |-> (mem_sel_n && done)); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !done) |=> ($stable(mem_addr) && $stable(mem_wdata) && !mem_sel_n)); // R7
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && done) |=> $stable(rdata)); // R6
endmodule

// File: rtl/dmem_zone_ctrl.sv
module dmem_zone_ctrl
    import dmz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              done,
    output logic              onchip,
    output logic [DATA_W-1:0] rdata
);
    logic [ZONE_W-1:0] zone;
    logic              is_onchip;
    logic [WAIT_W-1:0] wait_sel;

    dmz_decode u_decode (
        .addr      (req_addr),
        .zone      (zone),
        .is_onchip (is_onchip)
    );

    dmz_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .zone     (zone),
        .wait_sel (wait_sel)
    );

    dmz_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .is_onchip (is_onchip),
        .wait_sel  (wait_sel),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_sel_n (mem_sel_n),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .done      (done),
        .onchip    (onchip),
        .rdata     (rdata)
    );
endmodule

// File: tb/dmem_zone_ctrl_test.sv
`timescale 1ns/1ps
module dmem_zone_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [13:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] mem_rdata;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_sel_n, mem_rd_n, mem_wr_n, done, onchip;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] ext_word(logic [13:0] a);
        return {2'b01, a} ^ 16'hA5C3;
    endfunction

    assign mem_rdata = ext_word(mem_addr);

    dmem_zone_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .done(done), .onchip(onchip), .rdata(rdata)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic int zone_of(logic [13:0] a);
        if (a < 14'h0400) return 0;
        if (a < 14'h0800) return 1;
        if (a < 14'h3000) return 2;
        if (a < 14'h3400) return 3;
        return 4;
    endfunction

    int          m_rem;
    bit          m_int, m_we, m_idle;
    logic [13:0] m_addr;
    logic [15:0] m_wd, m_rd;
    int          m_cfg [5];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_int = 0; m_we = 0; m_addr = '0; m_wd = '0; m_rd = '0;
            for (int k = 0; k < 5; k++) m_cfg[k] = 7;
        end else begin
            m_idle = (m_rem == 0) && !m_int;
            if (m_int) m_int = 0;
            else if (m_rem > 0) begin
                if (m_rem == 1 && !m_we) m_rd = ext_word(m_addr);
                m_rem--;
            end
            if (m_idle && req) begin
                m_addr = req_addr; m_we = req_we; m_wd = req_wdata;
                if (req_addr >= 14'h3800) m_int = 1;
                else m_rem = m_cfg[zone_of(req_addr)] + 1;
            end
            if (cfg_we)
                for (int k = 0; k < 5; k++) m_cfg[k] = int'(cfg_wdata[3*k +: 3]);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check(mem_sel_n == !(m_rem > 0), "R3 sel_n", mem_sel_n, !(m_rem > 0));
            check(mem_rd_n == !(m_rem > 0 && !m_we), "R4 rd_n", mem_rd_n, !(m_rem > 0 && !m_we));
            check(mem_wr_n == !(m_rem > 0 && m_we), "R4 wr_n", mem_wr_n, !(m_rem > 0 && m_we));
            check(done == ((m_rem == 1) || m_int), "R3 done", done, (m_rem == 1) || m_int);
            check(onchip == m_int, "R5 onchip", onchip, m_int);
            check(mem_addr == m_addr, "R7 mem_addr", mem_addr, m_addr);
            check(mem_wdata == m_wd, "R7 mem_wdata", mem_wdata, m_wd);
            check(rdata == m_rd, "R6 rdata", rdata, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(bit we, logic [13:0] a, logic [15:0] wd, int exp_len, string tag);
        int len;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        len = 1;
        while (!done && len < 20) begin
            @(negedge clk);
            len++;
        end
        check(len == exp_len, tag, len, exp_len);
    endtask

    task automatic write_cfg(logic [14:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    logic [13:0] lo_addr [5] = '{14'h0000, 14'h0400, 14'h0800, 14'h3000, 14'h3400};
    logic [13:0] hi_addr [5] = '{14'h03FF, 14'h07FF, 14'h2FFF, 14'h33FF, 14'h37FF};
    int          prog    [5] = '{0, 3, 5, 1, 6};

    initial begin
        logic [14:0] cv;
        logic [15:0] held;
        int          len;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_sel_n && mem_rd_n && mem_wr_n, "R1 strobes idle", {mem_sel_n, mem_rd_n, mem_wr_n}, 3'b111);
        check(!done && !onchip, "R1 done/onchip low", {done, onchip}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R1/R2: default count 7 in every zone, both edges
        for (int z = 0; z < 5; z++) begin
            access(1'b0, lo_addr[z], 16'h0, 8, "R1 default length low edge");
            access(1'b1, hi_addr[z], 16'h1234 + 16'(z), 8, "R1 default length high edge");
        end

        // R2/R3: distinct programmed counts
        cv = '0;
        for (int z = 0; z < 5; z++) cv[3*z +: 3] = 3'(prog[z]);
        write_cfg(cv);
        for (int z = 0; z < 5; z++) begin
            access(1'b0, lo_addr[z], 16'h0, prog[z] + 1, "R2 zone length low edge");
            access(1'b0, hi_addr[z], 16'h0, prog[z] + 1, "R2 zone length high edge");
            access(1'b1, lo_addr[z] + 14'd5, 16'hBEE0 ^ 16'(z), prog[z] + 1, "R4 write length");
        end

        // R5: on-chip region
        access(1'b0, 14'h3800, 16'h0, 1, "R5 onchip low edge");
        access(1'b1, 14'h3FFF, 16'hFFFF, 1, "R5 onchip high edge");

        // R6: rdata held across a write and an on-chip read
        access(1'b0, 14'h0123, 16'h0, prog[0] + 1, "R6 read");
        @(negedge clk);
        held = rdata;
        check(held == ext_word(14'h0123), "R6 captured value", held, ext_word(14'h0123));
        access(1'b1, 14'h0200, 16'h5555, prog[0] + 1, "R6 write");
        access(1'b0, 14'h3900, 16'h0, 1, "R6 onchip read");
        @(negedge clk);
        check(rdata == held, "R6 rdata unchanged", rdata, held);

        // R8: request while busy is ignored
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 14'h3500; req_wdata = '0;
        @(negedge clk);
        req_addr = 14'h0001;   // still high while busy
        @(negedge clk);
        req = 1'b0;
        len = 2;
        while (!done && len < 20) begin @(negedge clk); len++; end
        check(len == prog[4] + 1, "R8 length not disturbed", len, prog[4] + 1);
        check(mem_addr == 14'h3500, "R8 address kept", mem_addr, 14'h3500);
        repeat (3) @(negedge clk);
        check(mem_sel_n, "R8 no later access", mem_sel_n, 1);

        // R9: config change during an access
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 14'h1000; req_wdata = 16'hC0DE;
        @(negedge clk);
        req = 1'b0;
        cfg_we = 1'b1; cfg_wdata = '0;
        @(negedge clk);
        cfg_we = 1'b0;
        len = 2;
        while (!done && len < 20) begin @(negedge clk); len++; end
        check(len == prog[2] + 1, "R9 latched count", len, prog[2] + 1);
        access(1'b0, 14'h1000, 16'h0, 1, "R9 new count applies");
        access(1'b0, 14'h37FF, 16'h0, 1, "R9 new count zone 4");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule